// File: doc/BRIEF.md
# SIMT Divergence Reconvergence Stack

This block holds the control-flow state of one warp of lock-stepped threads. After a data-dependent branch splits the warp, it runs the divergent paths one after another. When the last path arrives at the join point, it brings the full set of threads back together. Each stack slot records three things: the PC the slot resumes at, the PC where that slot's threads rejoin, and the set of lanes that slot enables. The warp always fetches from the slot on top and enables the lanes in that slot's mask.

The front end reports two kinds of event. The first is a resolved branch, carrying the per-lane taken bits, the branch target, the fall-through PC and the join PC. The join PC is computed elsewhere. The second is a plain PC advance, carrying the PC the warp moves to. A divergent branch rewrites the current top so that it resumes at the join PC. It then pushes the not-taken path and, above it, the taken path, so the taken path runs first. When an advance lands on the top slot's join PC, that slot is removed. The warp then continues from the slot beneath it, which ends with the full mask at the join block.

Top module: `simt_reconv_stack`

## Requirements
- R1: After reset the stack holds one slot: `cur_pc` equals the START_PC parameter, `cur_mask` is all ones, `stack_depth` is 1 and `overflow` is 0.
- R2: A step (`step_valid`=1, `br_valid`=0) whose PC is not the top slot's join PC sets `cur_pc` to `step_pc` on the next cycle and leaves `cur_mask` and `stack_depth` unchanged.
- R3: A branch is uniform when the taken bits ANDed with `cur_mask` are all zero or equal `cur_mask`. Taken bits of inactive lanes are ignored. A uniform branch moves to `br_target` if any active lane is taken and to `br_fallthru` otherwise, and pushes nothing.
- R4: A divergent branch whose target and fall-through both differ from the join PC adds two slots in one cycle. On the next cycle `cur_pc` is the target and `cur_mask` holds the taken active lanes. The slot below resumes at the fall-through PC with the remaining active lanes.
- R5: When a step or a uniform branch moves to the top slot's join PC while `stack_depth` is above 1, that slot is removed. On the next cycle the outputs show the slot below.
- R6: After every path of a divergence has reached the join PC, `cur_pc` is the join PC and `cur_mask` is the mask that was active before the branch.
- R7: A divergent path that starts at the join PC itself is not pushed, and `stack_depth` grows only by the number of paths actually pushed.
- R8: A divergent branch that needs more slots than remain free leaves the stack unchanged and sets `overflow`. The flag stays set until reset.
- R9: The last slot is never removed: at depth 1 every step only rewrites `cur_pc`, even a step to PC 0.
- R10: When `br_valid` and `step_valid` are both 1 in a cycle, only the branch is acted upon.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A resolved branch is presented this cycle |
| br_taken | input | LANES | Per-lane taken outcome |
| br_target | input | PC_W | Taken-path PC |
| br_fallthru | input | PC_W | Not-taken-path PC |
| br_reconv | input | PC_W | Join PC for this branch |
| step_valid | input | 1 | The warp advances to `step_pc` |
| step_pc | input | PC_W | PC the warp moves to |
| cur_pc | output | PC_W | PC of the top slot |
| cur_mask | output | LANES | Lanes enabled by the top slot |
| stack_depth | output | $clog2(DEPTH+1) | Number of occupied slots |
| overflow | output | 1 | Sticky: a divergent branch found no room |

## Verification
A corrupted slot below the top stays hidden until the pops reach it. It then shows up as a wrong `cur_pc` or `cur_mask` in the cycle right after that pop, which can be many cycles after the fault. A wrong depth count is visible at once on `stack_depth`. The bench therefore drives nested divergences and unwinds them completely, and a random run keeps landing steps on join PCs. Every cycle is compared with a behavioural queue model, so a buried fault is reported as soon as it surfaces.

// File: rtl/simt_rs_pkg.sv
package simt_rs_pkg;
  // Action applied to the slot currently on top
  typedef enum logic [1:0] {
    TOP_KEEP  = 2'd0,
    TOP_WRITE = 2'd1,
    TOP_POP   = 2'd2
  } top_act_e;
endpackage

// File: rtl/simt_rs_decide.sv
module simt_rs_decide
  import simt_rs_pkg::*;
#(
  parameter int LANES = 4,
  parameter int PC_W  = 16,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             br_valid,
  input  logic [LANES-1:0] br_taken,
  input  logic [PC_W-1:0]  br_target,
  input  logic [PC_W-1:0]  br_fallthru,
  input  logic [PC_W-1:0]  br_reconv,
  input  logic             step_valid,
  input  logic [PC_W-1:0]  step_pc,
  input  logic [PC_W-1:0]  top_rpc,
  input  logic [LANES-1:0] top_mask,
  input  logic [CNT_W-1:0] cnt,
  output top_act_e         act,
  output logic [PC_W-1:0]  top_wpc,
  output logic [1:0]       push_n,
  output logic [PC_W-1:0]  push0_pc,
  output logic [LANES-1:0] push0_mask,
  output logic [PC_W-1:0]  push1_pc,
  output logic [LANES-1:0] push1_mask,
  output logic [PC_W-1:0]  push_rpc,
  output logic             ovf_evt
);
  logic [LANES-1:0] eff_tk, eff_nt;
  logic             uniform, adv_req, need_ft, need_tk, room;
  logic [PC_W-1:0]  adv_pc;
  logic [1:0]       need_n;

  always_comb begin
    eff_tk  = br_taken & top_mask;
    eff_nt  = top_mask & ~eff_tk;
    uniform = (eff_tk == '0) || (eff_nt == '0);
    adv_pc  = br_valid ? ((eff_tk != '0) ? br_target : br_fallthru) : step_pc;
    adv_req = (br_valid && uniform) || (!br_valid && step_valid);
    need_ft = (br_fallthru != br_reconv);
    need_tk = (br_target != br_reconv);
    need_n  = {1'b0, need_ft} + {1'b0, need_tk};
    room    = (int'(cnt) + int'(need_n)) <= DEPTH;

    act        = TOP_KEEP;
    top_wpc    = adv_pc;
    push_n     = 2'd0;
    push0_pc   = br_fallthru;
    push0_mask = eff_nt;
    push1_pc   = br_target;
    push1_mask = eff_tk;
    push_rpc   = br_reconv;
    ovf_evt    = 1'b0;

    if (adv_req) begin
      if (cnt > CNT_W'(1) && adv_pc == top_rpc) act = TOP_POP;
      else                                      act = TOP_WRITE;
    end else if (br_valid) begin
      if (!room) begin
        ovf_evt = 1'b1;
      end else begin
        act     = TOP_WRITE;
        top_wpc = br_reconv;
        push_n  = need_n;
        if (!need_ft) begin
          // only the taken path needs a slot: it goes in the lower position
          push0_pc   = br_target;
          push0_mask = eff_tk;
        end
      end
    end
  end
endmodule

// File: rtl/simt_rs_store.sv
module simt_rs_store
  import simt_rs_pkg::*;
#(
  parameter int          LANES    = 4,
  parameter int          PC_W     = 16,
  parameter int          DEPTH    = 8,
  parameter int unsigned START_PC = 32'h10,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  top_act_e         act,
  input  logic [PC_W-1:0]  top_wpc,
  input  logic [1:0]       push_n,
  input  logic [PC_W-1:0]  push0_pc,
  input  logic [LANES-1:0] push0_mask,
  input  logic [PC_W-1:0]  push1_pc,
  input  logic [LANES-1:0] push1_mask,
  input  logic [PC_W-1:0]  push_rpc,
  output logic [PC_W-1:0]  top_pc,
  output logic [PC_W-1:0]  top_rpc,
  output logic [LANES-1:0] top_mask,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d, top_full, above_top;
  logic             cnt_en;
  logic [IDX_W-1:0] tix;
  logic [PC_W-1:0]  npc_all  [DEPTH];
  logic [PC_W-1:0]  rpc_all  [DEPTH];
  logic [LANES-1:0] mask_all [DEPTH];

  assign top_full  = cnt_q - CNT_W'(1);
  assign above_top = cnt_q + CNT_W'(1);
  assign tix       = IDX_W'(top_full);

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [PC_W-1:0]  npc_q, npc_d, rpc_q, rpc_d;
    logic [LANES-1:0] msk_q, msk_d;
    logic             en;

    always_comb begin
      en    = 1'b0;
      npc_d = npc_q;
      rpc_d = rpc_q;
      msk_d = msk_q;
      if (act == TOP_WRITE && top_full == CNT_W'(i)) begin
        en    = 1'b1;
        npc_d = top_wpc;
      end
      if (push_n != 2'd0 && cnt_q == CNT_W'(i)) begin
        en    = 1'b1;
        npc_d = push0_pc;
        rpc_d = push_rpc;
        msk_d = push0_mask;
      end
      if (push_n == 2'd2 && above_top == CNT_W'(i)) begin
        en    = 1'b1;
        npc_d = push1_pc;
        rpc_d = push_rpc;
        msk_d = push1_mask;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        npc_q <= (i == 0) ? PC_W'(START_PC) : '0;
        rpc_q <= '0;
        msk_q <= (i == 0) ? '1 : '0;
      end else if (en) begin
        npc_q <= npc_d;
        rpc_q <= rpc_d;
        msk_q <= msk_d;
      end
    end

    assign npc_all[i]  = npc_q;
    assign rpc_all[i]  = rpc_q;
    assign mask_all[i] = msk_q;
  end

  always_comb begin
    cnt_en = (act == TOP_POP) || (push_n != 2'd0);
    cnt_d  = (act == TOP_POP) ? top_full : (cnt_q + CNT_W'(push_n));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_W'(1);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign top_pc   = npc_all[tix];
  assign top_rpc  = rpc_all[tix];
  assign top_mask = mask_all[tix];
  assign cnt      = cnt_q;
endmodule

// File: rtl/simt_reconv_stack.sv
module simt_reconv_stack
  import simt_rs_pkg::*;
#(
  parameter int          LANES    = 4,
  parameter int          PC_W     = 16,
  parameter int          DEPTH    = 8,
  parameter int unsigned START_PC = 32'h10,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             br_valid,
  input  logic [LANES-1:0] br_taken,
  input  logic [PC_W-1:0]  br_target,
  input  logic [PC_W-1:0]  br_fallthru,
  input  logic [PC_W-1:0]  br_reconv,
  input  logic             step_valid,
  input  logic [PC_W-1:0]  step_pc,
  output logic [PC_W-1:0]  cur_pc,
  output logic [LANES-1:0] cur_mask,
  output logic [CNT_W-1:0] stack_depth,
  output logic             overflow
);
  top_act_e         act;
  logic [PC_W-1:0]  top_wpc, push0_pc, push1_pc, push_rpc, top_rpc;
  logic [LANES-1:0] push0_mask, push1_mask;
  logic [1:0]       push_n;
  logic             ovf_evt, ovf_q, ovf_d;

  simt_rs_decide #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_decide (
    .br_valid(br_valid), .br_taken(br_taken), .br_target(br_target),
    .br_fallthru(br_fallthru), .br_reconv(br_reconv),
    .step_valid(step_valid), .step_pc(step_pc),
    .top_rpc(top_rpc), .top_mask(cur_mask), .cnt(stack_depth),
    .act(act), .top_wpc(top_wpc), .push_n(push_n),
    .push0_pc(push0_pc), .push0_mask(push0_mask),
    .push1_pc(push1_pc), .push1_mask(push1_mask),
    .push_rpc(push_rpc), .ovf_evt(ovf_evt)
  );

  simt_rs_store #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .START_PC(START_PC)) u_store (
    .clk(clk), .rst_n(rst_n), .act(act), .top_wpc(top_wpc), .push_n(push_n),
    .push0_pc(push0_pc), .push0_mask(push0_mask),
    .push1_pc(push1_pc), .push1_mask(push1_mask), .push_rpc(push_rpc),
    .top_pc(cur_pc), .top_rpc(top_rpc), .top_mask(cur_mask), .cnt(stack_depth)
  );

  assign ovf_d = ovf_q | ovf_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovf_q <= 1'b0;
    else if (ovf_evt) ovf_q <= ovf_d;
  end

  assign overflow = ovf_q;
endmodule

// File: rtl/simt_rs_checker.sv
module simt_rs_checker #(
  parameter int LANES = 4,
  parameter int PC_W  = 16,
  parameter int DEPTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             br_valid,
  input logic [LANES-1:0] br_taken,
  input logic [PC_W-1:0]  br_target,
  input logic [PC_W-1:0]  br_fallthru,
  input logic [PC_W-1:0]  br_reconv,
  input logic             step_valid,
  input logic [PC_W-1:0]  step_pc,
  input logic [PC_W-1:0]  cur_pc,
  input logic [LANES-1:0] cur_mask,
  input logic [CNT_W-1:0] stack_depth,
  input logic             overflow,
  input logic [PC_W-1:0]  top_rpc
);
  logic [LANES-1:0] c_tk, c_nt;
  logic             c_uni, c_both, c_room;
  logic [PC_W-1:0]  c_dest;

  assign c_tk   = br_taken & cur_mask;
  assign c_nt   = cur_mask & ~c_tk;
  assign c_uni  = (c_tk == '0) || (c_nt == '0);
  assign c_both = (br_fallthru != br_reconv) && (br_target != br_reconv);
  assign c_room = (int'(stack_depth) + (br_fallthru != br_reconv ? 1 : 0)
                   + (br_target != br_reconv ? 1 : 0)) <= DEPTH;
  assign c_dest = (c_tk != '0) ? br_target : br_fallthru;

  assert_depth_bounds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stack_depth >= CNT_W'(1) && stack_depth <= CNT_W'(DEPTH));

  assert_mask_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cur_mask != '0);

  assert_bottom_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && !br_valid && stack_depth == CNT_W'(1)
    |=> stack_depth == CNT_W'(1) && cur_pc == $past(step_pc) && cur_mask == '1);

  assert_split_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && !c_uni && c_both && c_room
    |=> stack_depth == CNT_W'($past(stack_depth) + CNT_W'(2))
        && cur_mask == $past(c_tk) && cur_pc == $past(br_target));

  assert_uniform_move_R3: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && c_uni && stack_depth == CNT_W'(1)
    |=> cur_pc == $past(c_dest) && stack_depth == CNT_W'(1));

  assert_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    step_valid && !br_valid && stack_depth > CNT_W'(1) && step_pc == top_rpc
    |=> stack_depth == CNT_W'($past(stack_depth) - CNT_W'(1)));

  assert_overflow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid && !c_uni && !c_room
    |=> overflow && $stable(stack_depth) && $stable(cur_pc) && $stable(cur_mask));

  assert_overflow_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
endmodule

bind simt_reconv_stack simt_rs_checker #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_taken(br_taken),
  .br_target(br_target), .br_fallthru(br_fallthru), .br_reconv(br_reconv),
  .step_valid(step_valid), .step_pc(step_pc), .cur_pc(cur_pc), .cur_mask(cur_mask),
  .stack_depth(stack_depth), .overflow(overflow), .top_rpc(top_rpc)
);

// File: tb/sim_simt_reconv_stack.sv
module sim_simt_reconv_stack;
  localparam int LANES = 4;
  localparam int PC_W  = 16;
  localparam int DEPTH = 5;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PC_W-1:0] START = 16'h0010;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             br_valid = 1'b0, step_valid = 1'b0;
  logic [LANES-1:0] br_taken = '0;
  logic [PC_W-1:0]  br_target = '0, br_fallthru = '0, br_reconv = '0, step_pc = '0;
  logic [PC_W-1:0]  cur_pc;
  logic [LANES-1:0] cur_mask;
  logic [CNT_W-1:0] stack_depth;
  logic             overflow;

  int    n_cmp = 0, n_bad = 0;
  bit    finished = 0;
  string phase = "R1 reset";

  always #5 clk = ~clk;

  simt_reconv_stack #(.LANES(LANES), .PC_W(PC_W), .DEPTH(DEPTH), .START_PC(32'h10)) u0 (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_taken(br_taken),
    .br_target(br_target), .br_fallthru(br_fallthru), .br_reconv(br_reconv),
    .step_valid(step_valid), .step_pc(step_pc), .cur_pc(cur_pc), .cur_mask(cur_mask),
    .stack_depth(stack_depth), .overflow(overflow)
  );

  // Behavioural reference: a queue of slots, the last element is the top
  typedef struct packed {
    logic [PC_W-1:0]  npc;
    logic [PC_W-1:0]  rpc;
    logic [LANES-1:0] m;
  } ment_t;
  ment_t mstk[$];
  bit    movf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mstk.delete();
      mstk.push_back('{npc: START, rpc: '0, m: '1});
      movf = 0;
    end else begin
      logic [LANES-1:0] tk, nt;
      logic [PC_W-1:0]  dst;
      bit               adv;
      int               need;
      adv = 0;
      dst = step_pc;
      if (br_valid) begin
        tk = br_taken & mstk[$].m;
        nt = mstk[$].m & ~tk;
        if (tk == 0 || nt == 0) begin
          adv = 1;
          dst = (tk != 0) ? br_target : br_fallthru;
        end else begin
          need = (br_fallthru != br_reconv ? 1 : 0) + (br_target != br_reconv ? 1 : 0);
          if (mstk.size() + need > DEPTH) movf = 1;
          else begin
            mstk[mstk.size()-1].npc = br_reconv;
            if (br_fallthru != br_reconv) mstk.push_back('{npc: br_fallthru, rpc: br_reconv, m: nt});
            if (br_target != br_reconv)   mstk.push_back('{npc: br_target, rpc: br_reconv, m: tk});
          end
        end
      end else if (step_valid) adv = 1;
      if (adv) begin
        if (mstk.size() > 1 && dst == mstk[$].rpc) void'(mstk.pop_back());
        else mstk[mstk.size()-1].npc = dst;
      end
    end
  end

  task automatic compare_model();
    n_cmp++;
    if (cur_pc !== mstk[$].npc || cur_mask !== mstk[$].m ||
        int'(stack_depth) != mstk.size() || overflow !== movf) begin
      n_bad++;
      $display("FAIL %s: pc=%h mask=%b depth=%0d ovf=%b expected pc=%h mask=%b depth=%0d ovf=%b",
               phase, cur_pc, cur_mask, stack_depth, overflow,
               mstk[$].npc, mstk[$].m, mstk.size(), movf);
    end
  endtask

  task automatic expect_state(string tag, logic [PC_W-1:0] pc, logic [LANES-1:0] m, int d, bit o);
    n_cmp++;
    if (cur_pc !== pc || cur_mask !== m || int'(stack_depth) != d || overflow !== o) begin
      n_bad++;
      $display("FAIL %s: pc=%h mask=%b depth=%0d ovf=%b expected pc=%h mask=%b depth=%0d ovf=%b",
               tag, cur_pc, cur_mask, stack_depth, overflow, pc, m, d, o);
    end
  endtask

  // One cycle: inputs held across the edge, outputs sampled 2 ns after it
  task automatic tick();
    @(posedge clk);
    #2;
    compare_model();
    br_valid   = 1'b0;
    step_valid = 1'b0;
  endtask

  task automatic step(logic [PC_W-1:0] pc);
    step_valid = 1'b1; step_pc = pc;
    tick();
  endtask

  task automatic branch(logic [LANES-1:0] tk, logic [PC_W-1:0] tg,
                        logic [PC_W-1:0] ft, logic [PC_W-1:0] rc);
    br_valid = 1'b1; br_taken = tk; br_target = tg; br_fallthru = ft; br_reconv = rc;
    tick();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    phase = "R1 reset";
    expect_state("R1", 16'h0010, 4'b1111, 1, 0);

    phase = "R9 bottom";
    step(16'h0000);
    expect_state("R9", 16'h0000, 4'b1111, 1, 0);
    phase = "R2 step";
    step(16'h0014);
    expect_state("R2", 16'h0014, 4'b1111, 1, 0);

    // if/else diamond
    phase = "R4 if/else split";
    branch(4'b1001, 16'h0020, 16'h0018, 16'h0030);
    expect_state("R4", 16'h0020, 4'b1001, 3, 0);
    phase = "R3 inactive lanes ignored";
    branch(4'b0110, 16'h0070, 16'h0024, 16'h0030);
    expect_state("R3", 16'h0024, 4'b1001, 3, 0);
    phase = "R10 branch over step";
    br_valid = 1'b1; br_taken = 4'b1001; br_target = 16'h0028;
    br_fallthru = 16'h0026; br_reconv = 16'h0030;
    step_valid = 1'b1; step_pc = 16'h0030;
    tick();
    expect_state("R10", 16'h0028, 4'b1001, 3, 0);
    phase = "R5 pop to else path";
    step(16'h0030);
    expect_state("R5", 16'h0018, 4'b0110, 2, 0);
    step(16'h001c);
    phase = "R6 join";
    step(16'h0030);
    expect_state("R6", 16'h0030, 4'b1111, 1, 0);

    // nested diamond
    phase = "R4 nested outer";
    branch(4'b1100, 16'h0040, 16'h0050, 16'h0080);
    expect_state("R4", 16'h0040, 4'b1100, 3, 0);
    phase = "R4 nested inner";
    branch(4'b0100, 16'h0044, 16'h0048, 16'h0060);
    expect_state("R4", 16'h0044, 4'b0100, 5, 0);
    phase = "R5 nested pops";
    step(16'h0060);
    expect_state("R5", 16'h0048, 4'b1000, 4, 0);
    step(16'h0060);
    expect_state("R6", 16'h0060, 4'b1100, 3, 0);
    step(16'h0080);
    expect_state("R5", 16'h0050, 4'b0011, 2, 0);
    phase = "R5 pop by uniform branch";
    branch(4'b0011, 16'h0080, 16'h0054, 16'h00ff);
    expect_state("R6", 16'h0080, 4'b1111, 1, 0);

    phase = "R7 path at join";
    branch(4'b0011, 16'h0090, 16'h00a0, 16'h00a0);
    expect_state("R7", 16'h0090, 4'b0011, 2, 0);
    step(16'h00a0);
    expect_state("R7", 16'h00a0, 4'b1111, 1, 0);

    phase = "R8 overflow";
    branch(4'b1110, 16'h00b0, 16'h00c0, 16'h00f0);
    branch(4'b0110, 16'h00b4, 16'h00b8, 16'h00e0);
    expect_state("R8", 16'h00b4, 4'b0110, 5, 0);
    branch(4'b0010, 16'h00d0, 16'h00d4, 16'h00d8);
    expect_state("R8", 16'h00b4, 4'b0110, 5, 1);
    tick();
    expect_state("R8", 16'h00b4, 4'b0110, 5, 1);

    do_reset();
    phase = "R1 reset again";
    expect_state("R1", 16'h0010, 4'b1111, 1, 0);

    phase = "R2 R3 R4 R5 R7 R10 random";
    for (int k = 0; k < 600; k++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 25) begin
        br_valid    = 1'b1;
        br_taken    = LANES'($urandom);
        br_target   = PC_W'($urandom_range(0, 15) * 4);
        br_fallthru = PC_W'($urandom_range(0, 15) * 4);
        br_reconv   = PC_W'($urandom_range(0, 15) * 4);
      end
      if (r >= 15 && r < 80) begin
        step_valid = 1'b1;
        step_pc = ($urandom_range(0, 2) == 0) ? mstk[$].rpc : PC_W'($urandom_range(0, 15) * 4);
      end
      tick();
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule